// File: doc/BRIEF.md
# Peripheral-to-Pad Crossbar Multiplexer

This block decides which on-chip peripheral signal appears on each pad of a 99-pad general-purpose bank, and which pad each peripheral input listens to. It offers two routing methods that work side by side. Three fixed function groups (a four-line flash port, a two-line UART port and a ten-line memory-card port) each place a whole peripheral onto a preset set of pads with a single control field. In addition, each crossbar peripheral signal has its own select register that can steer it onto any pad of a 64-pad window covering pads 8 to 71.

A crossbar select holds an offset-by-one pad number: value n routes the signal to pad n + 7, and zero means the signal is not routed. Software programs the selects and the group control word through a simple write port. A write changes the routing once the clock edge that captures it has passed. Where routes collide, fixed groups win over crossbar routes, the flash group wins over the memory-card group, and among crossbar signals the one with the lower index wins. Pads that nothing claims are left undriven with output and enable both low.

Top module: `pxb_top`

## Requirements
- R1: Reset (rst high at a clock edge) clears every crossbar select and the group word. Afterwards no pad is driven (pad_out and pad_oe all 0) and every peripheral and group input return reads 0.
- R2: A write with wr_addr = i (i < NUM_SIG) loads wr_data into the select of crossbar signal i. A write with wr_addr = 255 loads the group word: bits [1:0] are the flash select, bit 2 enables the UART group and bit 3 enables the memory-card group. The new routing shows on the pads only after the clock edge that captures the write, and not before.
- R3: A select value n with 1 ≤ n ≤ 64 drives pad n + 7 from periph_out[i] and periph_oe[i], and periph_in[i] returns pad_in[n + 7].
- R4: A select value of 0, or one above 64, leaves the signal unrouted. Its periph_in reads 0 and it drives no pad.
- R5: When several crossbar signals select the same pad, the signal with the lowest index drives that pad. Every signal that selects the pad reads its input.
- R6: A pad claimed by no active group and no valid crossbar route has pad_out = 0 and pad_oe = 0.
- R7: A flash select of 1 maps flash lines 0..3 to pads 83, 84, 86 and 87. A flash select of 2 maps them to pads 76, 78, 79 and 81. Values 0 and 3 leave the flash group inactive. flash_in returns the mapped pad inputs while the group is active and 0 otherwise.
- R8: With the UART group enabled, line 0 (transmit) uses pad 88 and line 1 (receive) uses pad 89. uart0_in returns those two pads while the group is enabled and 0 otherwise.
- R9: With the memory-card group enabled, line k (0 to 9) uses pad 72 + k. emmc_in returns those pads while the group is enabled and 0 otherwise.
- R10: When flash select 2 and the memory-card group are both active, the flash lines drive the four shared pads and the memory-card lines drive the other six.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: crossbar signal index, or 255 for the group word |
| wr_data | input | 7 | Write data |
| periph_out | input | NUM_SIG | Crossbar peripheral output values |
| periph_oe | input | NUM_SIG | Crossbar peripheral output enables |
| periph_in | output | NUM_SIG | Crossbar peripheral input returns |
| flash_out | input | 4 | Flash group output values |
| flash_oe | input | 4 | Flash group output enables |
| flash_in | output | 4 | Flash group input returns |
| uart0_out | input | 2 | UART group output values |
| uart0_oe | input | 2 | UART group output enables |
| uart0_in | output | 2 | UART group input returns |
| emmc_out | input | 10 | Memory-card group output values |
| emmc_oe | input | 10 | Memory-card group output enables |
| emmc_in | output | 10 | Memory-card group input returns |
| pad_out | output | 99 | Pad output values |
| pad_oe | output | 99 | Pad output enables |
| pad_in | input | 99 | Pad input values |

## Verification
The hardest situation to create from the ports is a pad contested by two crossbar signals, because the lower-index winner can only be told apart when the two contenders drive different values. The stimulus programs signals 4 and 10 onto the same pad and gives them opposite output values, then swaps the values. It then unroutes the winner so that the other signal takes the pad over. The flash-over-card overlap is reached the same way, with the two groups driving opposite levels on their shared pads.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    localparam int NUM_PADS    = 99;
    localparam int WIN_BASE    = 8;
    localparam int WIN_SIZE    = 64;
    localparam int WIN_IDX_W   = $clog2(WIN_SIZE);
    localparam int SEL_W       = 7;
    localparam int ADDR_W      = 8;
    localparam logic [ADDR_W-1:0] GRP_ADDR = 8'hFF;

    localparam int FLASH_LINES = 4;
    localparam int UART0_LINES = 2;
    localparam int EMMC_LINES  = 10;
    localparam int UART0_BASE  = 88;
    localparam int EMMC_BASE   = 72;

    typedef enum logic [1:0] {
        FL_OFF   = 2'd0,
        FL_SET_A = 2'd1,
        FL_SET_B = 2'd2,
        FL_RSVD  = 2'd3
    } flash_sel_e;

    // Group word layout: [3] card enable, [2] uart enable, [1:0] flash select
    typedef struct packed {
        logic       emmc_en;
        logic       uart0_en;
        flash_sel_e flash;
    } grp_cfg_t;

    function automatic logic flash_active(flash_sel_e s);
        return (s == FL_SET_A) || (s == FL_SET_B);
    endfunction

    // Pad of flash line k for the chosen pad set
    function automatic int flash_pad(flash_sel_e s, int k);
        if (s == FL_SET_A)
            return 83 + k + ((k >= 2) ? 1 : 0);
        else if (s == FL_SET_B)
            return 76 + k + ((k >= 1) ? 1 : 0) + ((k >= 3) ? 1 : 0);
        return 0;
    endfunction

    function automatic logic sel_valid(logic [SEL_W-1:0] s);
        return (s != '0) && (int'(s) <= WIN_SIZE);
    endfunction

endpackage

// File: rtl/pxb_regs.sv
module pxb_regs
    import pxb_pkg::*;
#(
    parameter int NUM_SIG = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [SEL_W-1:0]     wr_data,
    output logic [SEL_W-1:0]     sel [NUM_SIG],
    output grp_cfg_t             grp_cfg
);

    logic [SEL_W-1:0] sel_q [NUM_SIG];
    grp_cfg_t         grp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SIG; i++) sel_q[i] <= '0;
            grp_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == GRP_ADDR) grp_q <= grp_cfg_t'(wr_data[3:0]);
            for (int i = 0; i < NUM_SIG; i++)
                if (wr_addr == ADDR_W'(i)) sel_q[i] <= wr_data;
        end
    end

    assign sel     = sel_q;
    assign grp_cfg = grp_q;

    a_r1_grp_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (grp_cfg == '0));

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_chk
        a_r1_sel_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (sel[i] == '0));
        a_r2_sel_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(i)) |=> (sel[i] == $past(wr_data)));
    end

endmodule

// File: rtl/pxb_xbar.sv
module pxb_xbar
    import pxb_pkg::*;
#(
    parameter int NUM_SIG = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     sel [NUM_SIG],
    input  logic [NUM_SIG-1:0]   periph_out,
    input  logic [NUM_SIG-1:0]   periph_oe,
    output logic [NUM_SIG-1:0]   periph_in,
    input  logic [WIN_SIZE-1:0]  win_in,
    output logic [WIN_SIZE-1:0]  win_hit,
    output logic [WIN_SIZE-1:0]  win_out,
    output logic [WIN_SIZE-1:0]  win_oe
);

    // Per window pad: scan from the top index down so the lowest index wins
    for (genvar p = 0; p < WIN_SIZE; p++) begin : g_pad
        logic hit, o, e;
        always_comb begin
            hit = 1'b0;
            o   = 1'b0;
            e   = 1'b0;
            for (int i = NUM_SIG - 1; i >= 0; i--) begin
                if (sel[i] == SEL_W'(p + 1)) begin
                    hit = 1'b1;
                    o   = periph_out[i];
                    e   = periph_oe[i];
                end
            end
        end
        assign win_hit[p] = hit;
        assign win_out[p] = o;
        assign win_oe[p]  = e;
    end

    // Per signal: input return from the selected pad
    for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
        logic [WIN_IDX_W-1:0] idx;
        logic                 rin;
        always_comb begin
            idx = WIN_IDX_W'(sel[i] - SEL_W'(1));
            rin = sel_valid(sel[i]) ? win_in[idx] : 1'b0;
        end
        assign periph_in[i] = rin;

        a_r3_route_hit: assert property (@(posedge clk) disable iff (rst)
            sel_valid(sel[i]) |-> win_hit[idx]);
    end

endmodule

// File: rtl/pxb_grp.sv
module pxb_grp
    import pxb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  grp_cfg_t                cfg,
    input  logic [FLASH_LINES-1:0]  flash_out,
    input  logic [FLASH_LINES-1:0]  flash_oe,
    output logic [FLASH_LINES-1:0]  flash_in,
    input  logic [UART0_LINES-1:0]  uart0_out,
    input  logic [UART0_LINES-1:0]  uart0_oe,
    output logic [UART0_LINES-1:0]  uart0_in,
    input  logic [EMMC_LINES-1:0]   emmc_out,
    input  logic [EMMC_LINES-1:0]   emmc_oe,
    output logic [EMMC_LINES-1:0]   emmc_in,
    input  logic [NUM_PADS-1:0]     pad_in,
    output logic [NUM_PADS-1:0]     claim,
    output logic [NUM_PADS-1:0]     gout,
    output logic [NUM_PADS-1:0]     goe
);

    logic flash_on;
    assign flash_on = flash_active(cfg.flash);

    // Later assignments override earlier ones: flash is applied last
    always_comb begin
        claim = '0;
        gout  = '0;
        goe   = '0;
        if (cfg.uart0_en) begin
            for (int k = 0; k < UART0_LINES; k++) begin
                claim[UART0_BASE + k] = 1'b1;
                gout[UART0_BASE + k]  = uart0_out[k];
                goe[UART0_BASE + k]   = uart0_oe[k];
            end
        end
        if (cfg.emmc_en) begin
            for (int k = 0; k < EMMC_LINES; k++) begin
                claim[EMMC_BASE + k] = 1'b1;
                gout[EMMC_BASE + k]  = emmc_out[k];
                goe[EMMC_BASE + k]   = emmc_oe[k];
            end
        end
        if (flash_on) begin
            for (int k = 0; k < FLASH_LINES; k++) begin
                claim[flash_pad(cfg.flash, k)] = 1'b1;
                gout[flash_pad(cfg.flash, k)]  = flash_out[k];
                goe[flash_pad(cfg.flash, k)]   = flash_oe[k];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < FLASH_LINES; k++)
            flash_in[k] = flash_on ? pad_in[flash_pad(cfg.flash, k)] : 1'b0;
        for (int k = 0; k < UART0_LINES; k++)
            uart0_in[k] = cfg.uart0_en ? pad_in[UART0_BASE + k] : 1'b0;
        for (int k = 0; k < EMMC_LINES; k++)
            emmc_in[k] = cfg.emmc_en ? pad_in[EMMC_BASE + k] : 1'b0;
    end

    a_r7_flash_set_a_claim: assert property (@(posedge clk) disable iff (rst)
        (cfg.flash == FL_SET_A) |-> (claim[83] && claim[84] && claim[86] && claim[87]));

    a_r10_flash_over_emmc: assert property (@(posedge clk) disable iff (rst)
        (cfg.flash == FL_SET_B && cfg.emmc_en) |->
            (gout[76] == flash_out[0] && goe[81] == flash_oe[3]));

endmodule

// File: rtl/pxb_top.sv
module pxb_top
    import pxb_pkg::*;
#(
    parameter int NUM_SIG = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [SEL_W-1:0]        wr_data,
    input  logic [NUM_SIG-1:0]      periph_out,
    input  logic [NUM_SIG-1:0]      periph_oe,
    output logic [NUM_SIG-1:0]      periph_in,
    input  logic [FLASH_LINES-1:0]  flash_out,
    input  logic [FLASH_LINES-1:0]  flash_oe,
    output logic [FLASH_LINES-1:0]  flash_in,
    input  logic [UART0_LINES-1:0]  uart0_out,
    input  logic [UART0_LINES-1:0]  uart0_oe,
    output logic [UART0_LINES-1:0]  uart0_in,
    input  logic [EMMC_LINES-1:0]   emmc_out,
    input  logic [EMMC_LINES-1:0]   emmc_oe,
    output logic [EMMC_LINES-1:0]   emmc_in,
    output logic [NUM_PADS-1:0]     pad_out,
    output logic [NUM_PADS-1:0]     pad_oe,
    input  logic [NUM_PADS-1:0]     pad_in
);

    logic [SEL_W-1:0]    sel [NUM_SIG];
    grp_cfg_t            grp_cfg;
    logic [WIN_SIZE-1:0] win_hit, win_out, win_oe;
    logic [NUM_PADS-1:0] claim, gout, goe;

    pxb_regs #(.NUM_SIG(NUM_SIG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel     (sel),
        .grp_cfg (grp_cfg)
    );

    pxb_xbar #(.NUM_SIG(NUM_SIG)) u_xbar (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .periph_in  (periph_in),
        .win_in     (pad_in[WIN_BASE +: WIN_SIZE]),
        .win_hit    (win_hit),
        .win_out    (win_out),
        .win_oe     (win_oe)
    );

    pxb_grp u_grp (
        .clk       (clk),
        .rst       (rst),
        .cfg       (grp_cfg),
        .flash_out (flash_out),
        .flash_oe  (flash_oe),
        .flash_in  (flash_in),
        .uart0_out (uart0_out),
        .uart0_oe  (uart0_oe),
        .uart0_in  (uart0_in),
        .emmc_out  (emmc_out),
        .emmc_oe   (emmc_oe),
        .emmc_in   (emmc_in),
        .pad_in    (pad_in),
        .claim     (claim),
        .gout      (gout),
        .goe       (goe)
    );

    // Pad assembly: a fixed group claim overrides any crossbar route
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        if (p >= WIN_BASE && p < WIN_BASE + WIN_SIZE) begin : g_win
            assign pad_out[p] = claim[p] ? gout[p] : win_out[p - WIN_BASE];
            assign pad_oe[p]  = claim[p] ? goe[p]
                                         : (win_hit[p - WIN_BASE] & win_oe[p - WIN_BASE]);
        end else begin : g_fixed
            assign pad_out[p] = gout[p];
            assign pad_oe[p]  = goe[p];

            a_r6_idle_pad: assert property (@(posedge clk) disable iff (rst)
                !claim[p] |-> (!pad_out[p] && !pad_oe[p]));
        end
    end

endmodule

// File: tb/pxb_top_tb_top.sv
module pxb_top_tb_top;

    localparam int CLK_P   = 10;
    localparam int NSIG    = 16;
    localparam int NPAD    = 99;
    localparam int NVEC    = 8;

    // {signal index, select value, expected pad or -1 for none}
    localparam int VEC [NVEC][3] = '{
        '{0,   1,  8},
        '{3,   3, 10},
        '{5,  20, 27},
        '{15, 64, 71},
        '{12, 33, 40},
        '{7,   0, -1},
        '{2,  65, -1},
        '{9, 127, -1}
    };
    localparam int FL_A [4] = '{83, 84, 86, 87};
    localparam int FL_B [4] = '{76, 78, 79, 81};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [6:0]        wr_data = '0;
    logic [NSIG-1:0]   periph_out = '0, periph_oe = '0, periph_in;
    logic [3:0]        flash_out = '0, flash_oe = '0, flash_in;
    logic [1:0]        uart0_out = '0, uart0_oe = '0, uart0_in;
    logic [9:0]        emmc_out = '0, emmc_oe = '0, emmc_in;
    logic [NPAD-1:0]   pad_out, pad_oe;
    logic [NPAD-1:0]   pad_in = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    pxb_top #(.NUM_SIG(NSIG)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
        .flash_out(flash_out), .flash_oe(flash_oe), .flash_in(flash_in),
        .uart0_out(uart0_out), .uart0_oe(uart0_oe), .uart0_in(uart0_in),
        .emmc_out(emmc_out), .emmc_oe(emmc_oe), .emmc_in(emmc_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 8'(addr);
        wr_data = 7'(data);
        @(negedge clk);
        wr_en   = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NPAD-1:0] ep_out, ep_oe;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state with every source active
        periph_out = '1; periph_oe = '1;
        flash_out = '1; flash_oe = '1; uart0_out = '1; uart0_oe = '1;
        emmc_out = '1; emmc_oe = '1; pad_in = '1;
        #1;
        check("R1 pad_oe", 128'(pad_oe), 0);
        check("R1 pad_out", 128'(pad_out), 0);
        check("R1 periph_in", 128'(periph_in), 0);
        check("R1 group_in", 128'({flash_in, uart0_in, emmc_in}), 0);

        // R3/R4: vector table
        for (int v = 0; v < NVEC; v++) begin
            int s, n, pd;
            s = VEC[v][0]; n = VEC[v][1]; pd = VEC[v][2];
            periph_out = '0; periph_oe = '0;
            wr(s, n);
            periph_out = NSIG'(1) << s;
            periph_oe  = NSIG'(1) << s;
            pad_in     = (pd >= 0) ? (NPAD'(1) << pd) : '1;
            #1;
            ep_out = (pd >= 0) ? (NPAD'(1) << pd) : '0;
            check(pd >= 0 ? "R3 route pad_out" : "R4 unrouted pad_out", 128'(pad_out), 128'(ep_out));
            check(pd >= 0 ? "R3 route pad_oe" : "R4 unrouted pad_oe", 128'(pad_oe), 128'(ep_out));
            check(pd >= 0 ? "R3 route periph_in" : "R4 unrouted periph_in", 128'(periph_in),
                  (pd >= 0) ? 128'(NSIG'(1) << s) : 0);
            wr(s, 0);
        end

        // R5: collision on pad 13, lowest index wins
        wr(4, 6);
        wr(10, 6);
        periph_oe  = (NSIG'(1) << 4) | (NSIG'(1) << 10);
        periph_out = NSIG'(1) << 10;
        pad_in     = NPAD'(1) << 13;
        #1;
        check("R5 low index drives 0", 128'(pad_out), 0);
        check("R5 pad_oe", 128'(pad_oe), 128'(NPAD'(1) << 13));
        check("R5 both read", 128'(periph_in), 128'(periph_oe));
        periph_out = NSIG'(1) << 4;
        #1;
        check("R5 low index drives 1", 128'(pad_out), 128'(NPAD'(1) << 13));
        wr(4, 0);
        periph_out = NSIG'(1) << 10;
        #1;
        check("R5 takeover by index 10", 128'(pad_out), 128'(NPAD'(1) << 13));
        wr(10, 0);

        // R2: change only after the capturing edge
        periph_out = '1; periph_oe = '1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd1; wr_data = 7'd5;
        #1;
        check("R2 before edge", 128'(pad_oe), 0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R2 after edge", 128'(pad_oe), 128'(NPAD'(1) << 12));
        wr(1, 0);
        check("R6 idle after clear", 128'(pad_oe), 0);
        periph_out = '0; periph_oe = '0;

        // R7: flash set A, others inactive but driving
        uart0_out = '1; uart0_oe = '1; emmc_out = '1; emmc_oe = '1;
        flash_out = 4'b0101; flash_oe = 4'b0011;
        wr(255, 1);
        pad_in = (NPAD'(1) << 83) | (NPAD'(1) << 87);
        #1;
        ep_out = '0; ep_oe = '0;
        for (int k = 0; k < 4; k++) begin
            ep_out[FL_A[k]] = flash_out[k];
            ep_oe[FL_A[k]]  = flash_oe[k];
        end
        check("R7 set A pad_out", 128'(pad_out), 128'(ep_out));
        check("R7 set A pad_oe", 128'(pad_oe), 128'(ep_oe));
        check("R7 set A flash_in", 128'(flash_in), 128'(4'b1001));

        wr(255, 2);
        pad_in = (NPAD'(1) << 78) | (NPAD'(1) << 81);
        #1;
        ep_out = '0; ep_oe = '0;
        for (int k = 0; k < 4; k++) begin
            ep_out[FL_B[k]] = flash_out[k];
            ep_oe[FL_B[k]]  = flash_oe[k];
        end
        check("R7 set B pad_out", 128'(pad_out), 128'(ep_out));
        check("R7 set B pad_oe", 128'(pad_oe), 128'(ep_oe));
        check("R7 set B flash_in", 128'(flash_in), 128'(4'b1010));

        wr(255, 3);
        pad_in = '1;
        #1;
        check("R7 value 3 inactive pad_oe", 128'(pad_oe), 0);
        check("R7 value 3 flash_in", 128'(flash_in), 0);

        // R8: UART group
        uart0_out = 2'b01; uart0_oe = 2'b11;
        wr(255, 4);
        pad_in = NPAD'(1) << 89;
        #1;
        check("R8 pad_out", 128'(pad_out), 128'(NPAD'(1) << 88));
        check("R8 pad_oe", 128'(pad_oe), 128'(NPAD'(3) << 88));
        check("R8 uart0_in", 128'(uart0_in), 128'(2'b10));

        // R9: memory-card group
        emmc_out = 10'b1010011001; emmc_oe = '1;
        wr(255, 8);
        pad_in = NPAD'(10'b0110001011) << 72;
        #1;
        check("R9 pad_out", 128'(pad_out), 128'(NPAD'(emmc_out) << 72));
        check("R9 pad_oe", 128'(pad_oe), 128'(NPAD'(10'h3FF) << 72));
        check("R9 emmc_in", 128'(emmc_in), 128'(10'b0110001011));
        check("R8 uart0_in off", 128'(uart0_in), 0);

        // R10: flash set B over memory-card group
        emmc_out = '1; emmc_oe = '1; flash_out = 4'b0000; flash_oe = 4'b1111;
        wr(255, 10);
        #1;
        ep_out = NPAD'(10'h3FF) << 72;
        for (int k = 0; k < 4; k++) ep_out[FL_B[k]] = 1'b0;
        check("R10 pad_out", 128'(pad_out), 128'(ep_out));
        check("R10 pad_oe", 128'(pad_oe), 128'(NPAD'(10'h3FF) << 72));

        // R1: reset in the middle of operation
        wr(0, 1);
        periph_out = '1; periph_oe = '1; pad_in = '1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 mid-run reset pad_oe", 128'(pad_oe), 0);
        check("R1 mid-run reset periph_in", 128'(periph_in), 0);
        check("R1 mid-run reset emmc_in", 128'(emmc_in), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule